// File: doc/BRIEF.md
# Parallel LCD Bus Interface Controller

This block connects a 32-bit internal command port to an 8-bit parallel bus that drives an external LCD controller. A write of one, two or four bytes is accepted as a single command and split into that many byte cycles on the external bus, least significant byte first. A read runs the same number of byte cycles and assembles the returned bytes into a 32-bit word. The result is published in two places: the main data register and a separate read-result register.

The control lines follow one of two signalling conventions chosen at run time. One uses separate active-low write and read strobes. The other uses a read/write level plus an active-high enable. The length of each byte cycle comes from a wait count and a cycle count. Both are measured in ticks of a time base that runs at the full clock rate or at 1/2, 1/4 or 1/32 of it.

A one-word write buffer lets software queue the next write while the current transfer is still on the bus. A sticky interrupt flag records the end of every access.

Top module: `lcd_bus_if`

## Requirements
- R1: `db_oe` is 1 for the whole of every write byte cycle and 0 during read byte cycles and when idle.
- R2: `cmd_size` 0 gives 1 byte cycle, 1 gives 2, and 2 or 3 give 4. Byte k of a transfer carries bits [8k+7:8k] of the word, with k counting up from 0.
- R3: A write command is accepted (`cmd_ready`=1) whenever the one-word buffer is empty, including while a transfer is on the bus. When the buffer is full, `cmd_ready` stays 0 and the held command is sent later without loss.
- R4: `tick_sel` 0, 1, 2 and 3 produce one timing tick every 1, 2, 4 and 32 clocks.
- R5: In each byte cycle the strobe is active for exactly `wst`+1 ticks, and `db_out` does not change while the strobe is active.
- R6: A byte cycle lasts max(`cyc`, `wst`+2)+1 ticks. This is the spacing between strobe starts of consecutive byte cycles of one busy period, including across queued accesses.
- R7: With `mode_6800`=0, `ctl_a` is an active-low write strobe and `ctl_b` an active-low read strobe, and both idle at 1. With `mode_6800`=1, `ctl_a` is read/write (1=read, 0=write, idle 1) and `ctl_b` is an active-high enable (idle 0).
- R8: A read samples `db_in` on the last clock of each strobe. At the end of the read, `read_reg` and `data_reg` both hold the assembled word, with unused upper bytes set to zero.
- R9: `irq` is set at the end of every access and stays set until `irq_clr` is pulsed. If a set and a clear happen in the same cycle, the set wins.
- R10: `busy` rises at the start of the first byte cycle and falls after the last one. It stays high without a gap when a queued write follows directly.
- R11: After a write command is accepted, `data_reg` holds `cmd_wdata` with the bytes beyond the access size set to zero.
- R12: A read command is accepted only when the write buffer is empty and no transfer is running or one is finishing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_6800 | input | 1 | 0: separate read/write strobes, 1: R/W plus enable |
| tick_sel | input | 2 | Time base select (divide by 1, 2, 4, 32) |
| wst | input | 4 | Strobe width in ticks, minus one |
| cyc | input | 4 | Byte cycle length in ticks, minus one |
| cmd_valid | input | 1 | Command request |
| cmd_write | input | 1 | 1: write, 0: read |
| cmd_size | input | 2 | Access size code |
| cmd_wdata | input | 32 | Write data |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| data_reg | output | 32 | Main data register |
| read_reg | output | 32 | Read-result register |
| busy | output | 1 | Bus transfer in progress |
| irq | output | 1 | Sticky completion flag |
| irq_clr | input | 1 | Clears the completion flag |
| db_out | output | 8 | Bus data driven out |
| db_in | input | 8 | Bus data read in |
| db_oe | output | 1 | Output enable for the bus data pins |
| ctl_a | output | 1 | Write strobe or R/W line |
| ctl_b | output | 1 | Read strobe or enable line |

## Verification
The hardest state to reach is a full write buffer while a multi-byte transfer is on the bus, with a further write held off. This is the only state in which the stall, the direct handoff from one access to the next, and the unbroken busy window all appear together. The stimulus issues two word writes back to back with a long cycle setting. It then holds a third write valid while sampling `cmd_ready`, and counts any idle clock of `busy` until all twelve bytes have been seen on the bus. A monitor measures strobe width and strobe spacing against each configuration, including the stretched cycle where `cyc` is below `wst`+2.

// File: rtl/lcd_bus_pkg.sv
package lcd_bus_pkg;
  localparam int BUS_W  = 8;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / BUS_W;
  localparam int LANE_W = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } xfer_size_e;

  // Index of the last byte lane used by an access of the given size.
  function automatic logic [LANE_W-1:0] last_lane(input logic [1:0] sz);
    case (xfer_size_e'(sz))
      SZ_BYTE: last_lane = LANE_W'(0);
      SZ_HALF: last_lane = LANE_W'(1);
      default: last_lane = LANE_W'(LANES - 1);
    endcase
  endfunction

  // Zero the bytes that lie beyond the access size.
  function automatic logic [WORD_W-1:0] size_mask(input logic [WORD_W-1:0] d,
                                                  input logic [1:0] sz);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < LANES; i++) begin
      if (LANE_W'(i) <= last_lane(sz)) m[i*BUS_W +: BUS_W] = '1;
    end
    size_mask = d & m;
  endfunction
endpackage

// File: rtl/lcd_tick_gen.sv
module lcd_tick_gen #(
  parameter int PRE_W = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  output logic       tick
);
  logic [PRE_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_comb begin
    case (sel)
      2'd0:    tick = 1'b1;
      2'd1:    tick = cnt_q[0];
      2'd2:    tick = &cnt_q[1:0];
      default: tick = &cnt_q;
    endcase
  end

  AST_HALF_RATE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'd1) && tick |=> (sel != 2'd1) || !tick); // R4
  AST_QUARTER_RATE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'd2) && tick |=> (sel != 2'd2) || !tick); // R4
endmodule

// File: rtl/lcd_wbuf.sv
module lcd_wbuf
  import lcd_bus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] push_data,
  input  logic [1:0]        push_size,
  input  logic              pop,
  output logic              valid,
  output logic [WORD_W-1:0] data,
  output logic [1:0]        size
);
  logic              valid_d;
  logic [WORD_W-1:0] data_d;
  logic [1:0]        size_d;

  always_comb begin
    valid_d = valid;
    data_d  = data;
    size_d  = size;
    if (push) begin
      valid_d = 1'b1;
      data_d  = push_data;
      size_d  = push_size;
    end else if (pop) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
      size  <= '0;
    end else begin
      valid <= valid_d;
      data  <= data_d;
      size  <= size_d;
    end
  end

  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !valid); // R3
  AST_POP_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> valid); // R3
endmodule

// File: rtl/lcd_byte_engine.sv
module lcd_byte_engine
  import lcd_bus_pkg::*;
#(
  parameter int WST_W = 4,
  parameter int CYC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [WST_W-1:0]  wst,
  input  logic [CYC_W-1:0]  cyc,
  input  logic              src_valid,
  input  logic              src_write,
  input  logic [1:0]        src_size,
  input  logic [WORD_W-1:0] src_data,
  output logic              src_take,
  output logic              free,
  output logic              active,
  output logic              is_write,
  output logic              strobe,
  output logic [BUS_W-1:0]  bus_byte,
  input  logic [BUS_W-1:0]  db_in,
  output logic              done,
  output logic [WORD_W-1:0] rd_word
);
  localparam int TW = ((WST_W > CYC_W) ? WST_W : CYC_W) + 1;

  logic [TW-1:0]     wst_x, cyc_x, last_t, strobe_end;
  logic [TW-1:0]     t_q, t_d;
  logic [LANE_W-1:0] bidx_q, bidx_d, nm1_q, nm1_d;
  logic              active_d, wr_d, strobe_d;
  logic [WORD_W-1:0] word_q, word_d, rd_q, rd_d;
  logic              byte_end, final_end, capture;

  always_comb begin
    wst_x      = TW'(wst);
    cyc_x      = TW'(cyc);
    strobe_end = wst_x + TW'(1);
    last_t     = (cyc_x > strobe_end) ? cyc_x : (wst_x + TW'(2));
  end

  always_comb begin
    byte_end  = active && tick && (t_q == last_t);
    final_end = byte_end && (bidx_q == nm1_q);
    free      = !active || final_end;
    src_take  = src_valid && free;
    capture   = active && !is_write && tick && (t_q == strobe_end);
  end

  always_comb begin
    active_d = active;
    wr_d     = is_write;
    nm1_d    = nm1_q;
    bidx_d   = bidx_q;
    t_d      = t_q;
    word_d   = word_q;
    rd_d     = rd_q;
    if (capture) rd_d[32'(bidx_q)*BUS_W +: BUS_W] = db_in;
    if (src_take) begin
      active_d = 1'b1;
      wr_d     = src_write;
      nm1_d    = last_lane(src_size);
      bidx_d   = '0;
      t_d      = '0;
      word_d   = src_data;
      rd_d     = '0;
    end else if (byte_end) begin
      t_d = '0;
      if (bidx_q == nm1_q) active_d = 1'b0;
      else                 bidx_d   = bidx_q + LANE_W'(1);
    end else if (active && tick) begin
      t_d = t_q + TW'(1);
    end
    strobe_d = active_d && (t_d != '0) && (t_d <= strobe_end);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      is_write <= 1'b0;
      nm1_q    <= '0;
      bidx_q   <= '0;
      t_q      <= '0;
      word_q   <= '0;
      rd_q     <= '0;
      strobe   <= 1'b0;
    end else begin
      active   <= active_d;
      is_write <= wr_d;
      nm1_q    <= nm1_d;
      bidx_q   <= bidx_d;
      t_q      <= t_d;
      word_q   <= word_d;
      rd_q     <= rd_d;
      strobe   <= strobe_d;
    end
  end

  assign bus_byte = word_q[32'(bidx_q)*BUS_W +: BUS_W];
  assign done     = final_end;
  assign rd_word  = rd_q;

  AST_TICK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> t_q <= last_t); // R6
  AST_LANE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> bidx_q <= nm1_q); // R2
  AST_STROBE_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> active); // R5
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && $past(strobe) |-> $stable(bus_byte)); // R5
endmodule

// File: rtl/lcd_bus_if.sv
module lcd_bus_if
  import lcd_bus_pkg::*;
#(
  parameter int WST_W = 4,
  parameter int CYC_W = 4,
  parameter int PRE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_6800,
  input  logic [1:0]        tick_sel,
  input  logic [WST_W-1:0]  wst,
  input  logic [CYC_W-1:0]  cyc,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [1:0]        cmd_size,
  input  logic [WORD_W-1:0] cmd_wdata,
  output logic              cmd_ready,
  output logic [WORD_W-1:0] data_reg,
  output logic [WORD_W-1:0] read_reg,
  output logic              busy,
  output logic              irq,
  input  logic              irq_clr,
  output logic [BUS_W-1:0]  db_out,
  input  logic [BUS_W-1:0]  db_in,
  output logic              db_oe,
  output logic              ctl_a,
  output logic              ctl_b
);
  logic              tick;
  logic              buf_valid, buf_push, buf_pop;
  logic [WORD_W-1:0] buf_data;
  logic [1:0]        buf_size;
  logic              src_valid, src_take, eng_free, eng_active, eng_wr;
  logic              eng_strobe, eng_done;
  logic [1:0]        src_size;
  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] data_d, read_d;
  logic              irq_d;

  lcd_tick_gen #(.PRE_W(PRE_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .sel(tick_sel), .tick(tick)
  );

  always_comb begin
    buf_push  = cmd_valid && cmd_write && !buf_valid;
    src_valid = buf_valid || (cmd_valid && !cmd_write);
    src_size  = buf_valid ? buf_size : cmd_size;
    buf_pop   = buf_valid && src_take;
    cmd_ready = cmd_write ? !buf_valid : (!buf_valid && eng_free);
  end

  lcd_wbuf u_wbuf (
    .clk(clk), .rst_n(rst_n),
    .push(buf_push), .push_data(cmd_wdata), .push_size(cmd_size),
    .pop(buf_pop), .valid(buf_valid), .data(buf_data), .size(buf_size)
  );

  lcd_byte_engine #(.WST_W(WST_W), .CYC_W(CYC_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wst(wst), .cyc(cyc),
    .src_valid(src_valid), .src_write(buf_valid), .src_size(src_size),
    .src_data(buf_data), .src_take(src_take), .free(eng_free),
    .active(eng_active), .is_write(eng_wr), .strobe(eng_strobe),
    .bus_byte(db_out), .db_in(db_in), .done(eng_done), .rd_word(rd_word)
  );

  always_comb begin
    data_d = data_reg;
    read_d = read_reg;
    if (eng_done && !eng_wr) begin
      data_d = rd_word;
      read_d = rd_word;
    end
    if (buf_push) data_d = size_mask(cmd_wdata, cmd_size);
    irq_d = eng_done ? 1'b1 : (irq_clr ? 1'b0 : irq);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_reg <= '0;
      read_reg <= '0;
      irq      <= 1'b0;
    end else begin
      data_reg <= data_d;
      read_reg <= read_d;
      irq      <= irq_d;
    end
  end

  always_comb begin
    busy  = eng_active;
    db_oe = eng_active && eng_wr;
    if (mode_6800) begin
      ctl_a = !(eng_active && eng_wr);
      ctl_b = eng_strobe;
    end else begin
      ctl_a = !(eng_strobe && eng_wr);
      ctl_b = !(eng_strobe && !eng_wr);
    end
  end

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq); // R9
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr && !eng_done |=> !irq); // R9
  AST_BUSY_FALL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq); // R10
  AST_READ_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_write && cmd_ready |-> !buf_valid && eng_free); // R12
endmodule

// File: tb/tb_lcd_bus_if.sv
module tb_lcd_bus_if;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_6800;
  logic [1:0]  tick_sel;
  logic [3:0]  wst, cyc;
  logic        cmd_valid, cmd_write;
  logic [1:0]  cmd_size;
  logic [31:0] cmd_wdata;
  logic        cmd_ready;
  logic [31:0] data_reg, read_reg;
  logic        busy, irq, irq_clr;
  logic [7:0]  db_out, db_in;
  logic        db_oe, ctl_a, ctl_b;

  int checks = 0;
  int failures = 0;
  int rd_cnt = 0;
  logic [7:0] exp_bytes[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_bus_if dut (
    .clk(clk), .rst_n(rst_n), .mode_6800(mode_6800), .tick_sel(tick_sel),
    .wst(wst), .cyc(cyc), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_size(cmd_size), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
    .data_reg(data_reg), .read_reg(read_reg), .busy(busy), .irq(irq),
    .irq_clr(irq_clr), .db_out(db_out), .db_in(db_in), .db_oe(db_oe),
    .ctl_a(ctl_a), .ctl_b(ctl_b)
  );

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] exp_mask(input logic [31:0] d, input logic [1:0] sz);
    if (sz == 2'd0) return {24'h0, d[7:0]};
    if (sz == 2'd1) return {16'h0, d[15:0]};
    return d;
  endfunction

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 29) + 60);
  endfunction

  function automatic int divf(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : (s == 2'd2) ? 4 : 32;
  endfunction

  function automatic int cyc_ticks(input int w, input int c);
    return ((c > w + 2) ? c : (w + 2)) + 1;
  endfunction

  assign db_in = pat(rd_cnt);

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bus monitor: strobe width, spacing, data hold, signalling and byte order.
  int   cyc_n = 0;
  bit   prev_strb = 1'b0, have_rise = 1'b0, held_wr = 1'b0;
  int   last_rise = 0, st_len = 0;
  logic [7:0] held;

  always @(posedge clk) cyc_n++;

  always @(negedge clk) begin
    bit strb;
    strb = mode_6800 ? ctl_b : (!ctl_a || !ctl_b);
    if (rst_n) begin
      if (strb && !prev_strb) begin
        if (have_rise)
          check((cyc_n - last_rise) == cyc_ticks(wst, cyc) * divf(tick_sel), "R6 spacing",
                32'(cyc_n - last_rise), 32'(cyc_ticks(wst, cyc) * divf(tick_sel)));
        last_rise = cyc_n;
        have_rise = 1'b1;
        st_len = 1;
        held = db_out;
        held_wr = db_oe;
        if (mode_6800)
          check(ctl_b && (ctl_a == !db_oe), "R7 6800 lines", {30'h0, ctl_a, ctl_b}, {30'h0, !db_oe, 1'b1});
        else
          check((ctl_a == !db_oe) && (ctl_b == db_oe), "R7 8080 lines",
                {30'h0, ctl_a, ctl_b}, {30'h0, !db_oe, db_oe});
      end else if (strb && prev_strb) begin
        st_len++;
        if (held_wr) check(db_out == held, "R5 data held", {24'h0, db_out}, {24'h0, held});
        check(db_oe == held_wr, "R1 oe steady", {31'h0, db_oe}, {31'h0, held_wr});
      end else if (!strb && prev_strb) begin
        check(st_len == (wst + 1) * divf(tick_sel), "R5 strobe width",
              32'(st_len), 32'((wst + 1) * divf(tick_sel)));
        if (held_wr) begin
          if (exp_bytes.size() == 0) check(1'b0, "R2 unexpected byte", {24'h0, held}, 32'h0);
          else begin
            logic [7:0] e;
            e = exp_bytes.pop_front();
            check(held == e, "R2 byte order", {24'h0, held}, {24'h0, e});
          end
        end else begin
          rd_cnt++;
        end
      end
      if (!busy) have_rise = 1'b0;
    end
    prev_strb = strb;
  end

  task automatic issue(input bit wr, input logic [1:0] sz, input logic [31:0] d);
    cmd_valid = 1'b1;
    cmd_write = wr;
    cmd_size  = sz;
    cmd_wdata = d;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_write = 1'b1;
  endtask

  task automatic wait_idle();
    while (!(!busy && cmd_ready)) @(negedge clk);
  endtask

  task automatic do_write(input logic [1:0] sz, input logic [31:0] d);
    for (int k = 0; k < nbytes(sz); k++) exp_bytes.push_back(d[k*8 +: 8]);
    issue(1'b1, sz, d);
  endtask

  task automatic do_read(input logic [1:0] sz);
    logic [31:0] e;
    int base;
    wait_idle();
    base = rd_cnt;
    e = '0;
    for (int k = 0; k < nbytes(sz); k++) e[k*8 +: 8] = pat(base + k);
    issue(1'b0, sz, 32'h0);
    wait_idle();
    check(read_reg == e, "R8 read_reg", read_reg, e);
    check(data_reg == e, "R8 data_reg", data_reg, e);
    check(irq == 1'b1, "R9 irq after read", {31'h0, irq}, 32'h1);
  endtask

  task automatic set_cfg(input bit m, input logic [1:0] s, input logic [3:0] w, input logic [3:0] c);
    wait_idle();
    mode_6800 = m;
    tick_sel  = s;
    wst       = w;
    cyc       = c;
    @(negedge clk);
  endtask

  task automatic write_and_check(input logic [1:0] sz, input logic [31:0] d);
    do_write(sz, d);
    wait_idle();
    check(exp_bytes.size() == 0, "R2 byte count", 32'(exp_bytes.size()), 32'h0);
    check(data_reg == exp_mask(d, sz), "R11 data_reg", data_reg, exp_mask(d, sz));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 32'(cyc_n), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] last_w;
    bit last_was_w;
    int gaps;
    void'($urandom(32'd4711));
    rst_n = 1'b0; mode_6800 = 1'b0; tick_sel = 2'd0; wst = 4'd2; cyc = 4'd6;
    cmd_valid = 1'b0; cmd_write = 1'b1; cmd_size = 2'd0; cmd_wdata = '0; irq_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    check(!busy, "R10 reset busy", {31'h0, busy}, 32'h0);
    check(!irq, "R9 reset irq", {31'h0, irq}, 32'h0);
    check(!db_oe, "R1 reset oe", {31'h0, db_oe}, 32'h0);
    check(ctl_a && ctl_b, "R7 8080 idle", {30'h0, ctl_a, ctl_b}, 32'h3);
    check(cmd_ready, "R3 reset ready", {31'h0, cmd_ready}, 32'h1);
    check(data_reg == 0 && read_reg == 0, "R11 reset regs", data_reg, 32'h0);

    // Sizes, LSB first
    write_and_check(2'd0, 32'h11223344);
    check(irq, "R9 irq set", {31'h0, irq}, 32'h1);
    write_and_check(2'd1, 32'hA1B2C3D4);
    write_and_check(2'd2, 32'h01234567);
    write_and_check(2'd3, 32'hFEDCBA98);

    // Reads of each size
    do_read(2'd0);
    do_read(2'd1);
    do_read(2'd2);

    // Stretched cycle when cyc < wst+2
    set_cfg(1'b0, 2'd0, 4'd4, 4'd1);
    write_and_check(2'd1, 32'h00005AA5);
    do_read(2'd1);

    // Slower time bases
    set_cfg(1'b0, 2'd1, 4'd1, 4'd3);
    write_and_check(2'd1, 32'h0000C0DE);
    set_cfg(1'b0, 2'd2, 4'd1, 4'd5);
    write_and_check(2'd1, 32'h0000BEEF);
    set_cfg(1'b0, 2'd3, 4'd1, 4'd3);
    write_and_check(2'd1, 32'h00007E81);

    // 6800 signalling
    set_cfg(1'b1, 2'd0, 4'd2, 4'd5);
    check(ctl_a && !ctl_b, "R7 6800 idle", {30'h0, ctl_a, ctl_b}, 32'h2);
    write_and_check(2'd2, 32'h89ABCDEF);
    do_read(2'd2);

    // Buffer full, stall, continuous busy, read held off
    set_cfg(1'b0, 2'd0, 4'd3, 4'd9);
    do_write(2'd2, 32'hAABBCCDD);
    repeat (3) @(negedge clk);
    cmd_write = 1'b0;
    #1 check(!cmd_ready, "R12 read held off while busy", {31'h0, cmd_ready}, 32'h0);
    cmd_write = 1'b1;
    #1 check(cmd_ready, "R3 write ready while busy", {31'h0, cmd_ready}, 32'h1);
    do_write(2'd2, 32'h55667788);
    check(busy, "R3 queued during transfer", {31'h0, busy}, 32'h1);
    for (int k = 0; k < 4; k++) exp_bytes.push_back(8'(32'h99E0F1C2 >> (k * 8)));
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_size = 2'd2; cmd_wdata = 32'h99E0F1C2;
    for (int k = 0; k < 3; k++) begin
      #1 check(!cmd_ready, "R3 stall when full", {31'h0, cmd_ready}, 32'h0);
      @(negedge clk);
    end
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    gaps = 0;
    while (exp_bytes.size() > 0) begin
      @(negedge clk);
      if (!busy) gaps++;
    end
    check(gaps == 0, "R10 busy continuous", 32'(gaps), 32'h0);
    wait_idle();
    check(data_reg == 32'h99E0F1C2, "R3 held write kept", data_reg, 32'h99E0F1C2);

    // Interrupt clear
    check(irq, "R9 sticky", {31'h0, irq}, 32'h1);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    check(!irq, "R9 cleared", {31'h0, irq}, 32'h0);
    @(negedge clk);
    check(!irq, "R9 stays clear", {31'h0, irq}, 32'h0);

    // Constrained random mix
    last_w = data_reg;
    last_was_w = 1'b1;
    for (int i = 0; i < 60; i++) begin
      if (i % 10 == 0)
        set_cfg(1'($urandom), 2'($urandom % 3), 4'($urandom % 6), 4'($urandom % 13));
      if ($urandom % 3 == 0) begin
        do_read(2'($urandom));
        last_was_w = 1'b0;
      end else begin
        logic [1:0] sz;
        logic [31:0] d;
        sz = 2'($urandom);
        d = $urandom;
        do_write(sz, d);
        last_w = exp_mask(d, sz);
        last_was_w = 1'b1;
      end
    end
    wait_idle();
    check(exp_bytes.size() == 0, "R2 random bytes drained", 32'(exp_bytes.size()), 32'h0);
    if (last_was_w) check(data_reg == last_w, "R11 random data_reg", data_reg, last_w);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule